// File: doc/BRIEF.md
# Flash Block Access Guard

This block sits beside a program flash and decides, for every table read or table write, whether the access is allowed. The flash is split into a boot region at the bottom of the address space and a row of equal power-of-two user regions above it. For each region the block keeps three active-low lock bits. One forbids writes. One fences reads so that only code running inside that region can see its contents. One shuts out the external programming port. Separate bits guard the data EEPROM against external access and against writes, and guard the configuration space against writes.

A request carries the target address, the address of the instruction that issued it, a write flag and an external-path flag. One cycle after the strobe, the block returns a grant bit and the read data. The read data is forced to zero wherever the rules hide it. A denied write also raises a one-cycle violation pulse. Lock bits can only be cleared by the write port. They return to 1 only through an erase command that arrives on the external path. A block erase restores the bits of one region. A chip erase restores every bit.

Top module: `fg_guard`

## Requirements
- R1: After reset, every lock bit reads 1 (lock_wr_n, lock_rd_n and lock_ext_n all 7'h7F; lock_misc_n 3'b111), and resp_valid and viol_pulse are 0.
- R2: A lock write ANDs prot_wr_data into the field chosen by prot_wr_field (0 write lock, 1 read fence, 2 external lock). Bit i is user slot i and bit 6 is the boot region. Writing 1 to a bit that is already 0 leaves it at 0.
- R3: An erase_cmd pulse acts only when erase_ext is 1. With erase_chip=1 it sets every lock bit. With erase_chip=0 it sets only the three bits of erase_region (0 to 5 for a user slot, 6 for boot). In the same cycle, an erase wins over a lock write to the same bit.
- R4: An internal write to a region whose write-lock bit is 0 is denied: resp_grant is 0 and viol_pulse is 1 for exactly that response cycle.
- R5: An internal read of a region whose read-fence bit is 0 is granted in every case. It returns rd_data_in when req_pc lies in the same region, and all-zero data otherwise.
- R6: The external-lock bits have no effect on internal requests. An external request is judged by the external-lock bit of its region alone. If that bit is 0 the request is denied with zero data, and an external write also raises viol_pulse.
- R7: Every request strobe produces exactly one response, registered and valid in the next cycle. There is no response in any other cycle.
- R8: An address below 2^BOOT_LOG2 belongs to the boot region. Other addresses belong to user slot addr>>BLK_LOG2. Addresses with a slot number of SLOTS or more are unguarded and always granted.
- R9: With PRESENT_SLOTS=5, the three lock bits of slot 5 read 1 permanently and cannot be cleared.
- R10: Field 3 of the lock write clears the side bits: bit 0 external EEPROM access, bit 1 EEPROM write, bit 2 configuration write. Only a chip erase sets them again; a block erase leaves them alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 for table write, 0 for table read |
| req_ext | input | 1 | Request comes from the external programming port |
| req_addr | input | ADDR_W | Flash address being accessed |
| req_pc | input | ADDR_W | Address of the instruction issuing the request |
| rd_data_in | input | DATA_W | Raw data from the flash array for this request |
| resp_valid | output | 1 | Response valid, one cycle after req_valid |
| resp_grant | output | 1 | Access granted |
| resp_rdata | output | DATA_W | Read data after masking |
| viol_pulse | output | 1 | One-cycle pulse on a denied write |
| prot_wr_en | input | 1 | Lock write strobe |
| prot_wr_field | input | 2 | Lock field selector: 0 write, 1 read fence, 2 external, 3 side bits |
| prot_wr_data | input | SLOTS+1 | Value ANDed into the chosen field |
| erase_cmd | input | 1 | Erase command pulse |
| erase_chip | input | 1 | 1 for chip erase, 0 for block erase |
| erase_ext | input | 1 | Erase originates from the external path |
| erase_region | input | $clog2(SLOTS+2) | Region restored by a block erase |
| lock_wr_n | output | SLOTS+1 | Write-lock bits, boot at the top bit |
| lock_rd_n | output | SLOTS+1 | Read-fence bits |
| lock_ext_n | output | SLOTS+1 | External-lock bits |
| lock_misc_n | output | 3 | EEPROM external, EEPROM write, configuration write lock bits |

## Verification
On every cycle, the assertions check that lock bits only fall unless an external erase fires, and that an erase leaves its target bits set. They also check that each strobe yields exactly one registered response, that denied responses carry zero data, that the violation pulse only comes with a denial, and that a fenced read from outside its region returns zeros. Only the bench scenarios show the region decode at the boundaries: the boot limit inside the first user slot, and the unguarded top of memory. The scenarios also cover erase winning over a same-cycle write, side bits surviving a block erase, an erase from the internal path being ignored, and the absent slot on the reduced variant.

// File: rtl/fg_pkg.sv
package fg_pkg;

   typedef enum logic [1:0] {
      FLD_WRITE = 2'd0,
      FLD_READ  = 2'd1,
      FLD_EXT   = 2'd2,
      FLD_MISC  = 2'd3
   } fg_field_e;

   localparam int MISC_W = 3;

   typedef struct packed {
      logic grant;
      logic pass;
   } fg_verdict_t;

endpackage

// File: rtl/fg_region_decode.sv
module fg_region_decode #(
   parameter int ADDR_W    = 16,
   parameter int BOOT_LOG2 = 11,
   parameter int BLK_LOG2  = 13,
   parameter int SLOTS     = 6,
   parameter int REG_W     = 3
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [REG_W-1:0]  region
);

   localparam logic [ADDR_W-1:0] BOOT_LIMIT = ADDR_W'(1 << BOOT_LOG2);
   localparam logic [REG_W-1:0]  BOOT_IDX   = REG_W'(SLOTS);
   localparam logic [REG_W-1:0]  NONE_IDX   = REG_W'(SLOTS + 1);

   logic [ADDR_W-1:0] blk_idx;
   assign blk_idx = addr >> BLK_LOG2;

   always_comb begin
      if (addr < BOOT_LIMIT)
         region = BOOT_IDX;
      else if (blk_idx < ADDR_W'(SLOTS))
         region = blk_idx[REG_W-1:0];
      else
         region = NONE_IDX;
   end

endmodule

// File: rtl/fg_prot_regs.sv
module fg_prot_regs
   import fg_pkg::*;
#(
   parameter int SLOTS         = 6,
   parameter int PRESENT_SLOTS = 6,
   parameter int REG_W         = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [1:0]          wr_field,
   input  logic [SLOTS:0]      wr_data,
   input  logic                erase_cmd,
   input  logic                erase_chip,
   input  logic                erase_ext,
   input  logic [REG_W-1:0]    erase_region,
   output logic [SLOTS:0]      wr_n,
   output logic [SLOTS:0]      rd_n,
   output logic [SLOTS:0]      ext_n,
   output logic [MISC_W-1:0]   misc_n
);

   logic erase_fire;
   assign erase_fire = erase_cmd & erase_ext;

   for (genvar i = 0; i <= SLOTS; i++) begin : g_slot
      if (i < PRESENT_SLOTS || i == SLOTS) begin : g_live
         logic [2:0] trio_q;
         logic       hit;
         assign hit = erase_fire && (erase_chip || erase_region == REG_W'(i));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               trio_q <= '1;
            end else if (hit) begin
               trio_q <= '1;
            end else if (wr_en) begin
               case (fg_field_e'(wr_field))
                  FLD_WRITE: trio_q[0] <= trio_q[0] & wr_data[i];
                  FLD_READ:  trio_q[1] <= trio_q[1] & wr_data[i];
                  FLD_EXT:   trio_q[2] <= trio_q[2] & wr_data[i];
                  default:   ;
               endcase
            end
         end

         assign wr_n[i]  = trio_q[0];
         assign rd_n[i]  = trio_q[1];
         assign ext_n[i] = trio_q[2];

         // R3: a matching external erase leaves the region fully unlocked
         assert_erase_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
            hit |=> (trio_q == 3'b111));
      end else begin : g_absent
         assign wr_n[i]  = 1'b1;
         assign rd_n[i]  = 1'b1;
         assign ext_n[i] = 1'b1;
      end
   end

   logic [MISC_W-1:0] misc_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         misc_q <= '1;
      else if (erase_fire && erase_chip)
         misc_q <= '1;
      else if (wr_en && fg_field_e'(wr_field) == FLD_MISC)
         misc_q <= misc_q & wr_data[MISC_W-1:0];
   end
   assign misc_n = misc_q;

   // R2: without an external erase no lock bit may rise
   assert_clear_only_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !erase_fire |=> ((wr_n & ~$past(wr_n)) == '0));
   assert_clear_only_rd_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !erase_fire |=> ((rd_n & ~$past(rd_n)) == '0));
   assert_clear_only_ext_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !erase_fire |=> ((ext_n & ~$past(ext_n)) == '0));
   // R10: side bits rise only through a chip erase
   assert_misc_chip_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(erase_fire && erase_chip) |=> ((misc_n & ~$past(misc_n)) == '0));
   // R3: chip erase sets every bit
   assert_chip_erase_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_fire && erase_chip) |=> (&wr_n && &rd_n && &ext_n && &misc_n));

endmodule

// File: rtl/fg_access_check.sv
module fg_access_check
   import fg_pkg::*;
#(
   parameter int SLOTS  = 6,
   parameter int DATA_W = 8,
   parameter int REG_W  = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               req_write,
   input  logic               req_ext,
   input  logic [REG_W-1:0]   reg_addr,
   input  logic [REG_W-1:0]   reg_pc,
   input  logic [DATA_W-1:0]  rd_data_in,
   input  logic [SLOTS:0]     wr_n,
   input  logic [SLOTS:0]     rd_n,
   input  logic [SLOTS:0]     ext_n,
   output logic               resp_valid,
   output logic               resp_grant,
   output logic [DATA_W-1:0]  resp_rdata,
   output logic               viol_pulse
);

   // Unguarded region sits one above boot and reads as fully unlocked.
   logic [SLOTS+1:0] wr_x, rd_x, ext_x;
   assign wr_x  = {1'b1, wr_n};
   assign rd_x  = {1'b1, rd_n};
   assign ext_x = {1'b1, ext_n};

   fg_verdict_t v;
   always_comb begin
      if (req_ext) begin
         v.grant = ext_x[reg_addr];
         v.pass  = ext_x[reg_addr];
      end else if (req_write) begin
         v.grant = wr_x[reg_addr];
         v.pass  = 1'b0;
      end else begin
         v.grant = 1'b1;
         v.pass  = rd_x[reg_addr] | (reg_pc == reg_addr);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_valid <= 1'b0;
         resp_grant <= 1'b0;
         resp_rdata <= '0;
         viol_pulse <= 1'b0;
      end else begin
         resp_valid <= req_valid;
         resp_grant <= req_valid & v.grant;
         resp_rdata <= (req_valid && !req_write && v.pass) ? rd_data_in : '0;
         viol_pulse <= req_valid & req_write & ~v.grant;
      end
   end

   // R7: one registered response per strobe
   assert_resp_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> resp_valid);
   assert_resp_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !resp_valid);
   // R6: a denied response never leaks data
   assert_deny_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && !resp_grant) |-> (resp_rdata == '0));
   // R4: violation pulse only accompanies a denial
   assert_viol_deny_R4: assert property (@(posedge clk) disable iff (!rst_n)
      viol_pulse |-> (resp_valid && !resp_grant));
   // R5: fenced read from another region completes with zeros
   assert_fenced_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && !req_ext && reg_pc != reg_addr && !rd_x[reg_addr])
      |=> (resp_grant && resp_rdata == '0));

endmodule

// File: rtl/fg_guard.sv
module fg_guard
   import fg_pkg::*;
#(
   parameter int ADDR_W        = 16,
   parameter int DATA_W        = 8,
   parameter int BOOT_LOG2     = 11,
   parameter int BLK_LOG2      = 13,
   parameter int SLOTS         = 6,
   parameter int PRESENT_SLOTS = 6
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   input  logic                       req_write,
   input  logic                       req_ext,
   input  logic [ADDR_W-1:0]          req_addr,
   input  logic [ADDR_W-1:0]          req_pc,
   input  logic [DATA_W-1:0]          rd_data_in,
   output logic                       resp_valid,
   output logic                       resp_grant,
   output logic [DATA_W-1:0]          resp_rdata,
   output logic                       viol_pulse,
   input  logic                       prot_wr_en,
   input  logic [1:0]                 prot_wr_field,
   input  logic [SLOTS:0]             prot_wr_data,
   input  logic                       erase_cmd,
   input  logic                       erase_chip,
   input  logic                       erase_ext,
   input  logic [$clog2(SLOTS+2)-1:0] erase_region,
   output logic [SLOTS:0]             lock_wr_n,
   output logic [SLOTS:0]             lock_rd_n,
   output logic [SLOTS:0]             lock_ext_n,
   output logic [MISC_W-1:0]          lock_misc_n
);

   localparam int REG_W = $clog2(SLOTS + 2);

   if (BLK_LOG2 >= ADDR_W || BOOT_LOG2 > BLK_LOG2) begin : g_bad_geometry
      $error("fg_guard: boot limit must fit in the first user slot and slots in the address space");
   end
   if (PRESENT_SLOTS < 1 || PRESENT_SLOTS > SLOTS) begin : g_bad_present
      $error("fg_guard: PRESENT_SLOTS must lie in 1..SLOTS");
   end
   if (SLOTS + DATA_W < 2) begin : g_bad_width
      $error("fg_guard: degenerate widths");
   end

   logic [REG_W-1:0] reg_addr, reg_pc;

   fg_region_decode #(
      .ADDR_W(ADDR_W), .BOOT_LOG2(BOOT_LOG2), .BLK_LOG2(BLK_LOG2),
      .SLOTS(SLOTS), .REG_W(REG_W)
   ) u_dec_addr (
      .addr(req_addr), .region(reg_addr)
   );

   fg_region_decode #(
      .ADDR_W(ADDR_W), .BOOT_LOG2(BOOT_LOG2), .BLK_LOG2(BLK_LOG2),
      .SLOTS(SLOTS), .REG_W(REG_W)
   ) u_dec_pc (
      .addr(req_pc), .region(reg_pc)
   );

   fg_prot_regs #(
      .SLOTS(SLOTS), .PRESENT_SLOTS(PRESENT_SLOTS), .REG_W(REG_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(prot_wr_en), .wr_field(prot_wr_field), .wr_data(prot_wr_data),
      .erase_cmd(erase_cmd), .erase_chip(erase_chip), .erase_ext(erase_ext),
      .erase_region(erase_region),
      .wr_n(lock_wr_n), .rd_n(lock_rd_n), .ext_n(lock_ext_n), .misc_n(lock_misc_n)
   );

   fg_access_check #(
      .SLOTS(SLOTS), .DATA_W(DATA_W), .REG_W(REG_W)
   ) u_check (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_ext(req_ext),
      .reg_addr(reg_addr), .reg_pc(reg_pc), .rd_data_in(rd_data_in),
      .wr_n(lock_wr_n), .rd_n(lock_rd_n), .ext_n(lock_ext_n),
      .resp_valid(resp_valid), .resp_grant(resp_grant),
      .resp_rdata(resp_rdata), .viol_pulse(viol_pulse)
   );

   // R1: nothing answers in the first cycle out of reset without a strobe
   assert_no_spurious_viol_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !viol_pulse);

endmodule

// File: tb/fg_guard_tb.sv
`timescale 1ns/100ps
module fg_guard_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_ext = 1'b0;
   logic [15:0] req_addr = '0, req_pc = '0;
   logic [7:0]  rd_data_in = '0;
   logic        resp_valid, resp_grant, viol_pulse;
   logic [7:0]  resp_rdata;
   logic        prot_wr_en = 1'b0;
   logic [1:0]  prot_wr_field = '0;
   logic [6:0]  prot_wr_data = '0;
   logic        erase_cmd = 1'b0, erase_chip = 1'b0, erase_ext = 1'b0;
   logic [2:0]  erase_region = '0;
   logic [6:0]  lock_wr_n, lock_rd_n, lock_ext_n;
   logic [2:0]  lock_misc_n;

   logic        s_resp_valid, s_resp_grant, s_viol;
   logic [7:0]  s_resp_rdata;
   logic [6:0]  s_wr_n, s_rd_n, s_ext_n;
   logic [2:0]  s_misc_n;

   always #2.5 clk = ~clk;

   fg_guard u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_ext(req_ext), .req_addr(req_addr), .req_pc(req_pc), .rd_data_in(rd_data_in),
      .resp_valid(resp_valid), .resp_grant(resp_grant), .resp_rdata(resp_rdata),
      .viol_pulse(viol_pulse), .prot_wr_en(prot_wr_en), .prot_wr_field(prot_wr_field),
      .prot_wr_data(prot_wr_data), .erase_cmd(erase_cmd), .erase_chip(erase_chip),
      .erase_ext(erase_ext), .erase_region(erase_region), .lock_wr_n(lock_wr_n),
      .lock_rd_n(lock_rd_n), .lock_ext_n(lock_ext_n), .lock_misc_n(lock_misc_n)
   );

   fg_guard #(.PRESENT_SLOTS(5)) u_dut_small (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_ext(req_ext), .req_addr(req_addr), .req_pc(req_pc), .rd_data_in(rd_data_in),
      .resp_valid(s_resp_valid), .resp_grant(s_resp_grant), .resp_rdata(s_resp_rdata),
      .viol_pulse(s_viol), .prot_wr_en(prot_wr_en), .prot_wr_field(prot_wr_field),
      .prot_wr_data(prot_wr_data), .erase_cmd(erase_cmd), .erase_chip(erase_chip),
      .erase_ext(erase_ext), .erase_region(erase_region), .lock_wr_n(s_wr_n),
      .lock_rd_n(s_rd_n), .lock_ext_n(s_ext_n), .lock_misc_n(s_misc_n)
   );

   typedef struct {
      logic       grant;
      logic [7:0] data;
      logic       viol;
      string      tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_cmp = 0;
   int   n_bad = 0;
   bit   done  = 1'b0;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // driver: one request, expected result pushed to the scoreboard
   task automatic do_req(input logic wr, input logic ext, input logic [15:0] addr,
                         input logic [15:0] pc, input logic [7:0] din,
                         input logic g, input logic [7:0] d, input logic vio,
                         input string tag);
      exp_t e;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_ext = ext;
      req_addr = addr; req_pc = pc; rd_data_in = din;
      e.grant = g; e.data = d; e.viol = vio; e.tag = tag;
      exp_q.push_back(e);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic ctl(input logic we, input logic [1:0] f, input logic [6:0] d,
                      input logic er, input logic chip, input logic ext,
                      input logic [2:0] region);
      @(negedge clk);
      prot_wr_en = we; prot_wr_field = f; prot_wr_data = d;
      erase_cmd = er; erase_chip = chip; erase_ext = ext; erase_region = region;
      @(negedge clk);
      prot_wr_en = 1'b0; erase_cmd = 1'b0;
   endtask

   task automatic check_locks(input string tag, input logic [6:0] w, input logic [6:0] r,
                              input logic [6:0] x, input logic [2:0] m);
      check({tag, " wr"}, 32'(lock_wr_n), 32'(w));
      check({tag, " rd"}, 32'(lock_rd_n), 32'(r));
      check({tag, " ext"}, 32'(lock_ext_n), 32'(x));
      check({tag, " misc"}, 32'(lock_misc_n), 32'(m));
   endtask

   // monitor: compares every response against the front of the queue
   always @(negedge clk) begin
      if (rst_n && resp_valid) begin
         if (exp_q.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R7: unexpected response actual 1 expected 0");
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check({e.tag, " grant"}, 32'(resp_grant), 32'(e.grant));
            check({e.tag, " data"}, 32'(resp_rdata), 32'(e.data));
            check({e.tag, " viol"}, 32'(viol_pulse), 32'(e.viol));
         end
      end else if (rst_n && viol_pulse) begin
         n_cmp++; n_bad++;
         $display("FAIL R4: viol without response actual 1 expected 0");
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 resp_valid", 32'(resp_valid), 32'h0);
      check("R1 viol", 32'(viol_pulse), 32'h0);
      check_locks("R1 reset", 7'h7F, 7'h7F, 7'h7F, 3'h7);
      check("R1 small wr", 32'(s_wr_n), 32'h7F);
      rst_n = 1'b1;
      @(negedge clk);

      // open flash: everything granted
      do_req(0, 0, 16'h4010, 16'h0100, 8'hA5, 1, 8'hA5, 0, "R7 int read open");
      do_req(0, 1, 16'h2000, 16'h0000, 8'h3C, 1, 8'h3C, 0, "R6 ext read open");
      do_req(1, 0, 16'h0100, 16'h0100, 8'hFF, 1, 8'h00, 0, "R7 int write open");

      // R2 / R4 write lock on slot 1
      ctl(1, 2'd0, 7'h7D, 0, 0, 0, 3'd0);
      check("R2 wr cleared", 32'(lock_wr_n), 32'h7D);
      do_req(1, 0, 16'h2100, 16'h0100, 8'h00, 0, 8'h00, 1, "R4 locked write");
      do_req(1, 0, 16'h4000, 16'h0100, 8'h00, 1, 8'h00, 0, "R4 unlocked write");
      ctl(1, 2'd0, 7'h7F, 0, 0, 0, 3'd0);
      check("R2 one ignored", 32'(lock_wr_n), 32'h7D);

      // R5 read fence on slot 2
      ctl(1, 2'd1, 7'h7B, 0, 0, 0, 3'd0);
      do_req(0, 0, 16'h4010, 16'h1000, 8'h5A, 1, 8'h00, 0, "R5 fenced from outside");
      do_req(0, 0, 16'h4010, 16'h5000, 8'h5A, 1, 8'h5A, 0, "R5 fenced from inside");

      // R8 boot and slot 0 fenced; boundary at the boot limit
      ctl(1, 2'd1, 7'h3A, 0, 0, 0, 3'd0);
      check("R2 rd and", 32'(lock_rd_n), 32'h3A);
      do_req(0, 0, 16'h0200, 16'h1000, 8'h77, 1, 8'h00, 0, "R8 boot from slot0");
      do_req(0, 0, 16'h0200, 16'h0300, 8'h77, 1, 8'h77, 0, "R8 boot from boot");
      do_req(0, 0, 16'h0900, 16'h0300, 8'h66, 1, 8'h00, 0, "R8 slot0 from boot");
      do_req(0, 0, 16'h0900, 16'h0A00, 8'h66, 1, 8'h66, 0, "R8 slot0 from slot0");
      do_req(0, 0, 16'hC000, 16'h0100, 8'h99, 1, 8'h99, 0, "R8 unguarded");

      // R6 external lock on slot 3
      ctl(1, 2'd2, 7'h77, 0, 0, 0, 3'd0);
      do_req(0, 0, 16'h6000, 16'h0100, 8'h42, 1, 8'h42, 0, "R6 int read ext-locked");
      do_req(1, 0, 16'h6000, 16'h0100, 8'h00, 1, 8'h00, 0, "R6 int write ext-locked");
      do_req(0, 1, 16'h6000, 16'h0000, 8'h42, 0, 8'h00, 0, "R6 ext read locked");
      do_req(1, 1, 16'h6000, 16'h0000, 8'h00, 0, 8'h00, 1, "R6 ext write locked");
      do_req(0, 1, 16'h8000, 16'h0000, 8'h24, 1, 8'h24, 0, "R6 ext read open slot");
      do_req(0, 1, 16'h4010, 16'h0000, 8'h11, 1, 8'h11, 0, "R6 ext read fenced slot");

      // R10 side bits
      ctl(1, 2'd3, 7'h05, 0, 0, 0, 3'd0);
      check("R10 misc cleared", 32'(lock_misc_n), 32'h5);

      // R3 erase from internal path ignored
      ctl(0, 2'd0, 7'h00, 1, 1, 0, 3'd0);
      check_locks("R3 internal erase ignored", 7'h7D, 7'h3A, 7'h77, 3'h5);

      // R3 block erase of slot 2, then boot; R10 side bits survive
      ctl(0, 2'd0, 7'h00, 1, 0, 1, 3'd2);
      check_locks("R3 block erase slot2", 7'h7D, 7'h3E, 7'h77, 3'h5);
      ctl(0, 2'd0, 7'h00, 1, 0, 1, 3'd6);
      check_locks("R10 boot erase keeps misc", 7'h7D, 7'h7E, 7'h77, 3'h5);

      // R3 erase wins over simultaneous write
      ctl(1, 2'd0, 7'h00, 1, 0, 1, 3'd1);
      check("R3 erase beats write", 32'(lock_wr_n), 32'h02);

      // R3 chip erase
      ctl(0, 2'd0, 7'h00, 1, 1, 1, 3'd0);
      check_locks("R3 chip erase", 7'h7F, 7'h7F, 7'h7F, 3'h7);

      // R9 reduced variant: slot 5 stays at 1
      ctl(1, 2'd0, 7'h00, 0, 0, 0, 3'd0);
      ctl(1, 2'd1, 7'h00, 0, 0, 0, 3'd0);
      ctl(1, 2'd2, 7'h00, 0, 0, 0, 3'd0);
      check("R9 full wr", 32'(lock_wr_n), 32'h00);
      check("R9 small wr", 32'(s_wr_n), 32'h20);
      check("R9 small rd", 32'(s_rd_n), 32'h20);
      check("R9 small ext", 32'(s_ext_n), 32'h20);

      repeat (3) @(negedge clk);
      check("R7 all responses seen", 32'(exp_q.size()), 32'h0);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule